// File: doc/BRIEF.md
# Random number generator control unit

This block is the register-side controller of a hardware random number generator. Software reaches it over a simple 32-bit register bus with single-cycle accesses. Through that bus it starts self-test and seeding jobs, polls their progress, reads random words from a small output FIFO and clears error and interrupt state. One level interrupt line reports finished jobs and errors. A read of the FIFO while it is empty has a programmable response.

The entropy source and its conditioning are replaced by a deterministic stand-in. A self-test lasts `ST_CYCLES` cycles and reports the 3-bit result code applied on `src_test_code`. A seed job lasts `SEED_CYCLES` cycles. Random word number k, counted from reset, is `WORD_ADD + k*WORD_MUL` (modulo 2^32). The FIFO refills one word per cycle, and only when it has run empty.

Register word index (`bus_addr`): 0 command, 1 control, 2 status, 3 error, 4 FIFO output. Writes go only to indices 0 and 1. Reads of any other index return zero.

Top module: `rng_ctl`

## Requirements
- R1: Command bits: bit 6 soft reset, bit 5 clear-error, bit 4 clear-interrupt, bit 1 generate-seed, bit 0 self-test. Bits 6, 5 and 4 always read 0. Bits 1 and 0 read 1 from the write until their job has finished, then clear by themselves.
- R2: When self-test and generate-seed are written together, the self-test finishes before the seed job completes. When the self-test bit clears, the seed bit still reads 1 and first-seed-done is still 0.
- R3: A self-test keeps status bit 1 (busy) high for exactly `ST_CYCLES` cycles. When it ends it sets status bit 4 (self-test done) and copies `src_test_code` into status bits 23:21. A nonzero code sets error bit 3. That bit is sticky: only reset, soft reset or clear-error clear it. Starting a new self-test clears status bit 4.
- R4: A finished seed job sets status bit 5 (first seed done) and status bit 6 (new seed done).
- R5: Status bits 15:12 always read 5, the FIFO depth. Bits 11:8 give the FIFO level. Bit 2 is idle and bit 1 is busy. No word is produced before the first seed. After a reset the status reads 0x00005004.
- R6: FIFO reads (index 4) return words in order. Word k, counted from reset, is `WORD_ADD + k*WORD_MUL`. An empty FIFO is refilled up to 5 words.
- R7: Once `RESEED_WORDS` words have been produced since the last seed, status bit 3 (reseed required) sets and no further word is produced. If control bit 4 (auto-reseed) is 1, a seed job starts without a command, which clears bit 3 and lets production resume.
- R8: Underflow mode is control bits 1:0. A read of an empty FIFO always returns 0. Modes 00 and 01 set error bit 5. Mode 10 raises `bus_err` and sets no flag. Mode 11 raises the interrupt even when errors are masked, and sets no flag.
- R9: The interrupt sets when a job finishes, unless control bit 5 (done mask) is 1. It also sets when an error flag sets, unless control bit 6 (error mask) is 1.
- R10: Clear-interrupt drops the interrupt only when no error flag is set. Clear-error clears all error flags and the interrupt. Status bit 16 is the OR of the error flags.
- R11: Soft reset returns the job state, the FIFO, the word sequence and all status and error flags to their reset values in one cycle. The control register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Bus transfer error for the access |
| src_test_code | input | 3 | Self-test result code from the source model |
| irq | output | 1 | Interrupt request, level |

## Verification
Several properties are checked on every cycle: the FIFO level stays within its depth, it grows only after a seed and never while a reseed is pending, an underflow read in modes 00/01 latches the flag while mode 10 leaves it untouched, the self-test error stays sticky, the clear commands act, and a self-test bit can only drop together with self-test-done. The bench scenarios are needed for everything that depends on order or on values: the exact job duration, self-test running before seeding, the word sequence across refills and an auto-reseed, the masking combinations of the interrupt, and the soft reset leaving the control register intact while restarting the sequence.

// File: rtl/rng_ctl.sv
module rng_ctl #(
  parameter int          DEPTH        = 5,
  parameter int          ST_CYCLES    = 6,
  parameter int          SEED_CYCLES  = 10,
  parameter int          RESEED_WORDS = 12,
  parameter logic [31:0] WORD_MUL     = 32'h9E37_79B9,
  parameter logic [31:0] WORD_ADD     = 32'h0BAD_5EED
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_err,
  input  logic [2:0]  src_test_code,
  output logic        irq
);
  timeunit 1ns; timeprecision 100ps;

  localparam int JMAX = (ST_CYCLES > SEED_CYCLES) ? ST_CYCLES : SEED_CYCLES;
  localparam int JW   = $clog2(JMAX + 1);
  localparam int LW   = $clog2(DEPTH + 1);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW   = $clog2(RESEED_WORDS + 1);

  typedef enum logic [1:0] {S_IDLE, S_TEST, S_SEED, S_FILL} fsm_t;

  typedef struct packed {
    fsm_t          fsm;
    logic [JW-1:0] jc;
    logic          st_pend, gs_pend, st_done, fsd, nsd, e_uf, e_st, irq;
    logic [2:0]    code;
    logic [LW-1:0] lvl;
    logic [PW-1:0] rp, wp;
    logic [SW-1:0] since;
    logic [31:0]   word;
  } core_t;

  localparam core_t CORE_RST = '{fsm: S_IDLE, word: WORD_ADD, default: '0};

  core_t q, n;
  logic [1:0]  uf_mode;
  logic        auto_rs, msk_done, msk_err;
  logic [31:0] mem [DEPTH];

  wire wr_cmd   = bus_sel &&  bus_wr && bus_addr == 3'd0;
  wire wr_ctl   = bus_sel &&  bus_wr && bus_addr == 3'd1;
  wire rd_fifo  = bus_sel && !bus_wr && bus_addr == 3'd4;
  wire srst     = wr_cmd && bus_wdata[6];
  wire clr_err  = wr_cmd && bus_wdata[5];
  wire clr_int  = wr_cmd && bus_wdata[4];
  wire empty    = q.lvl == '0;
  wire pop      = rd_fifo && !empty;
  wire undflow  = rd_fifo && empty;
  wire reseed_req = q.since == SW'(RESEED_WORDS);
  wire push     = q.fsm == S_FILL && q.lvl != LW'(DEPTH) && !reseed_req;
  wire job_last = (q.fsm == S_TEST) ? (q.jc == JW'(ST_CYCLES - 1))
                                    : (q.jc == JW'(SEED_CYCLES - 1));
  wire test_end = q.fsm == S_TEST && job_last;
  wire seed_end = q.fsm == S_SEED && job_last;
  wire err_evt  = (undflow && !uf_mode[1]) || (test_end && src_test_code != 3'd0);
  wire irq_set  = ((test_end || seed_end) && !msk_done) || (err_evt && !msk_err)
                  || (undflow && uf_mode == 2'b11);
  wire idle     = q.fsm == S_IDLE;
  wire [3:0] lvl4 = 4'(q.lvl);

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:7], bus_wdata[3:2]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {msk_err, msk_done, auto_rs, uf_mode} <= '0;
    else if (wr_ctl) {msk_err, msk_done, auto_rs, uf_mode} <= {bus_wdata[6:4], bus_wdata[1:0]};

  always_comb begin
    n = q;
    if (clr_err) begin
      n.e_uf = 1'b0;
      n.e_st = 1'b0;
      n.irq  = 1'b0;
    end
    if (clr_int && !(q.e_uf || q.e_st)) n.irq = 1'b0;
    case (q.fsm)
      S_IDLE:
        if (q.st_pend) begin
          n.fsm = S_TEST; n.jc = '0; n.st_done = 1'b0;
        end else if (q.gs_pend || (auto_rs && reseed_req)) begin
          n.fsm = S_SEED; n.jc = '0; n.gs_pend = 1'b1; n.nsd = 1'b0;
        end else if (q.fsd && empty && !reseed_req) begin
          n.fsm = S_FILL;
        end
      S_TEST:
        if (job_last) begin
          n.fsm = S_IDLE; n.st_pend = 1'b0; n.st_done = 1'b1;
          n.code = src_test_code;
          if (src_test_code != 3'd0) n.e_st = 1'b1;
        end else n.jc = q.jc + 1'b1;
      S_SEED:
        if (job_last) begin
          n.fsm = S_IDLE; n.gs_pend = 1'b0; n.fsd = 1'b1; n.nsd = 1'b1; n.since = '0;
        end else n.jc = q.jc + 1'b1;
      default:
        if (push) begin
          n.word  = q.word + WORD_MUL;
          n.since = q.since + 1'b1;
          n.wp    = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end else n.fsm = S_IDLE;
    endcase
    if (wr_cmd && bus_wdata[0]) n.st_pend = 1'b1;
    if (wr_cmd && bus_wdata[1]) n.gs_pend = 1'b1;
    if (pop) n.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
    n.lvl = q.lvl + LW'(push) - LW'(pop);
    if (undflow && !uf_mode[1]) n.e_uf = 1'b1;
    if (irq_set) n.irq = 1'b1;
    if (srst) n = CORE_RST;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= CORE_RST;
    else        q <= n;

  always_ff @(posedge clk)
    if (push) mem[q.wp] <= q.word;

  always_comb begin
    bus_rdata = '0;
    bus_err   = 1'b0;
    if (bus_sel && !bus_wr)
      case (bus_addr)
        3'd0: bus_rdata = {30'b0, q.gs_pend, q.st_pend};
        3'd1: bus_rdata = {25'b0, msk_err, msk_done, auto_rs, 2'b0, uf_mode};
        3'd2: bus_rdata = {8'b0, q.code, 4'b0, q.e_uf | q.e_st, 4'(DEPTH), lvl4,
                           1'b0, q.nsd, q.fsd, q.st_done, reseed_req, idle, !idle, 1'b0};
        3'd3: bus_rdata = {26'b0, q.e_uf, 1'b0, q.e_st, 3'b0};
        3'd4: if (!empty) bus_rdata = mem[q.rp];
              else        bus_err   = uf_mode == 2'b10;
        default: ;
      endcase
  end

  assign irq = q.irq;
endmodule

module rng_ctl_chk #(
  parameter int DEPTH = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_err,
  input logic        irq,
  input logic [1:0]  mode,
  input logic [3:0]  lvl,
  input logic        fsd,
  input logic        st_pend,
  input logic        st_done,
  input logic        e_uf,
  input logic        e_st,
  input logic        reseed,
  input logic        idle
);
  timeunit 1ns; timeprecision 100ps;

  wire wr_cmd  = bus_sel && bus_wr && bus_addr == 3'd0;
  wire srst    = wr_cmd && bus_wdata[6];
  wire rd_fifo = bus_sel && !bus_wr && bus_addr == 3'd4;

  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= 4'(DEPTH));

  // R5
  fill_after_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl > $past(lvl)) |-> fsd);

  // R7
  reseed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> !(lvl > $past(lvl)));

  // R8
  uf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fifo && lvl == 4'd0 && !mode[1]) |=> e_uf);

  // R8
  uf_buserr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fifo && lvl == 4'd0 && mode == 2'b10) |-> bus_err ##1 $stable(e_uf));

  // R3
  st_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_st && !(wr_cmd && (bus_wdata[5] || bus_wdata[6]))) |=> e_st);

  // R10
  clr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && bus_wdata[5] && idle) |=> (!e_uf && !e_st && !irq));

  // R10
  clr_int_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && bus_wdata[4] && !bus_wdata[5] && !bus_wdata[6] && (e_uf || e_st) && irq) |=> irq);

  // R1
  st_bit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_pend) && !$past(srst)) |-> st_done);
endmodule

bind rng_ctl rng_ctl_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_err(bus_err), .irq(irq),
  .mode(uf_mode), .lvl(lvl4), .fsd(q.fsd), .st_pend(q.st_pend),
  .st_done(q.st_done), .e_uf(q.e_uf), .e_st(q.e_st), .reseed(reseed_req),
  .idle(idle)
);

// File: tb/rng_ctl_tb_top.sv
module rng_ctl_tb_top;
  timeunit 1ns; timeprecision 100ps;

  localparam int          DEPTH = 5, STC = 6, SDC = 10, RSW = 12;
  localparam logic [31:0] MUL = 32'h9E37_79B9, ADD = 32'h0BAD_5EED;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_err, irq;
  logic [2:0]  src_test_code = '0;
  int          total = 0, failed = 0;

  always #2 clk = ~clk;

  rng_ctl #(.DEPTH(DEPTH), .ST_CYCLES(STC), .SEED_CYCLES(SDC), .RESEED_WORDS(RSW),
            .WORD_MUL(MUL), .WORD_ADD(ADD)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .src_test_code(src_test_code), .irq(irq));

  function automatic logic [31:0] word_k(input int k);
    return ADD + MUL * 32'(k);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata; e = bus_err;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] d;
    logic        e;
    int          quiet = 0;
    repeat (4) @(posedge clk);
    for (int i = 0; i < 400 && quiet < 2; i++) begin
      rd(3'd2, d, e);
      quiet = d[1] ? 0 : quiet + 1;
    end
    if (quiet < 2) chk({req, " idle timeout"}, 32'd1, 32'd0);
  endtask

  task automatic wait_cmd(input logic [31:0] mask, input string req, output logic [31:0] last);
    logic e;
    last = mask;
    for (int i = 0; i < 400 && (last & mask) != 0; i++) rd(3'd0, last, e);
    if ((last & mask) != 0) chk({req, " command timeout"}, last & mask, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        e;
    int          nbusy;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd(3'd2, d, e); chk("R5 status after reset", d, 32'h0000_5004);
    rd(3'd0, d, e); chk("R1 command after reset", d, 32'h0);
    rd(3'd3, d, e); chk("R10 error after reset", d, 32'h0);
    chk("R9 irq after reset", {31'b0, irq}, 32'd0);

    // read before first seed: underflow in mode 00
    rd(3'd4, d, e);
    chk("R5 no word before seed", d, 32'h0);
    chk("R8 mode00 no bus error", {31'b0, e}, 32'd0);
    rd(3'd3, d, e); chk("R8 mode00 underflow flag", d, 32'h20);
    chk("R9 irq on error", {31'b0, irq}, 32'd1);
    rd(3'd2, d, e); chk("R10 error summary bit", d, 32'h0001_5004);
    wr(3'd0, 32'h10);
    chk("R10 clear-int kept by error", {31'b0, irq}, 32'd1);
    rd(3'd0, d, e); chk("R1 clear bits read zero", d, 32'h0);
    wr(3'd0, 32'h20);
    rd(3'd3, d, e); chk("R10 clear-error flags", d, 32'h0);
    chk("R10 clear-error irq", {31'b0, irq}, 32'd0);

    // self-test duration and done interrupt
    wr(3'd0, 32'h01);
    nbusy = 0;
    for (int i = 0; i < 20; i++) begin
      rd(3'd2, d, e);
      if (d[1]) nbusy++;
    end
    chk("R3 self-test busy cycles", 32'(nbusy), 32'(STC));
    rd(3'd2, d, e); chk("R3 self-test done status", d, 32'h0000_5014);
    rd(3'd0, d, e); chk("R1 self-test bit cleared", d, 32'h0);
    chk("R9 irq on done", {31'b0, irq}, 32'd1);
    wr(3'd0, 32'h10);
    chk("R10 clear-int without error", {31'b0, irq}, 32'd0);

    // self-test and seed together, failing self-test, done masked
    wr(3'd1, 32'h20);
    src_test_code = 3'd5;
    wr(3'd0, 32'h03);
    wait_cmd(32'h1, "R2", d);
    chk("R2 seed bit still set after self-test", {31'b0, d[1]}, 32'd1);
    rd(3'd2, d, e);
    chk("R2 self-test done first", {31'b0, d[4]}, 32'd1);
    chk("R2 seed not yet done", {31'b0, d[5]}, 32'd0);
    chk("R3 result code", {29'b0, d[23:21]}, 32'd5);
    rd(3'd3, d, e); chk("R3 self-test error flag", d, 32'h08);
    chk("R9 error irq with done masked", {31'b0, irq}, 32'd1);
    wait_cmd(32'h2, "R4", d);
    rd(3'd2, d, e);
    chk("R4 seed done bits", {30'b0, d[6:5]}, 32'd3);
    wr(3'd0, 32'h10);
    chk("R10 clear-int kept by self-test error", {31'b0, irq}, 32'd1);

    // new passing self-test: done clears at start, error stays
    wait_idle("R3");
    src_test_code = 3'd0;
    wr(3'd0, 32'h01);
    rd(3'd2, d, e);
    rd(3'd2, d, e); chk("R3 done cleared on new self-test", {31'b0, d[4]}, 32'd0);
    wait_cmd(32'h1, "R3", d);
    rd(3'd3, d, e); chk("R3 self-test error sticky", d, 32'h08);
    rd(3'd2, d, e); chk("R3 new code recorded", {29'b0, d[23:21]}, 32'd0);
    wr(3'd0, 32'h20);
    rd(3'd3, d, e); chk("R10 clear-error sticky flag", d, 32'h0);
    chk("R10 clear-error drops irq", {31'b0, irq}, 32'd0);

    // FIFO contents across refills
    wait_idle("R6");
    rd(3'd2, d, e); chk("R5 level full", {28'b0, d[11:8]}, 32'(DEPTH));
    for (int k = 0; k < 5; k++) begin
      rd(3'd4, d, e); chk("R6 word first fill", d, word_k(k));
    end
    wait_idle("R6");
    rd(3'd2, d, e); chk("R6 refill level", {28'b0, d[11:8]}, 32'(DEPTH));
    for (int k = 5; k < 10; k++) begin
      rd(3'd4, d, e); chk("R6 word second fill", d, word_k(k));
    end
    wait_idle("R7");
    rd(3'd2, d, e);
    chk("R7 partial fill level", {28'b0, d[11:8]}, 32'(RSW - 10));
    chk("R7 reseed required", {31'b0, d[3]}, 32'd1);
    for (int k = 10; k < RSW; k++) begin
      rd(3'd4, d, e); chk("R7 word before reseed", d, word_k(k));
    end
    wait_idle("R7");
    rd(3'd2, d, e);
    chk("R7 no words while reseed needed", {28'b0, d[11:8]}, 32'd0);
    chk("R7 idle while reseed needed", {30'b0, d[2:1]}, 32'd2);

    // underflow modes
    wr(3'd1, 32'h21);
    rd(3'd4, d, e);
    chk("R8 mode01 data zero", d, 32'h0);
    chk("R8 mode01 no bus error", {31'b0, e}, 32'd0);
    rd(3'd3, d, e); chk("R8 mode01 flag", d, 32'h20);
    chk("R9 mode01 irq", {31'b0, irq}, 32'd1);
    wr(3'd0, 32'h20);
    wr(3'd1, 32'h22);
    rd(3'd4, d, e);
    chk("R8 mode10 bus error", {31'b0, e}, 32'd1);
    chk("R8 mode10 data zero", d, 32'h0);
    rd(3'd3, d, e); chk("R8 mode10 no flag", d, 32'h0);
    chk("R8 mode10 no irq", {31'b0, irq}, 32'd0);
    wr(3'd1, 32'h63);
    rd(3'd4, d, e);
    chk("R8 mode11 data zero", d, 32'h0);
    chk("R8 mode11 irq despite mask", {31'b0, irq}, 32'd1);
    rd(3'd3, d, e); chk("R8 mode11 no flag", d, 32'h0);
    wr(3'd0, 32'h10);
    chk("R10 clear-int mode11", {31'b0, irq}, 32'd0);
    wr(3'd1, 32'h60);
    rd(3'd4, d, e);
    rd(3'd3, d, e); chk("R9 masked error flag", d, 32'h20);
    chk("R9 masked error no irq", {31'b0, irq}, 32'd0);
    wr(3'd0, 32'h20);

    // auto-reseed
    wr(3'd1, 32'h30);
    wait_idle("R7");
    rd(3'd2, d, e);
    chk("R7 auto reseed cleared", {31'b0, d[3]}, 32'd0);
    chk("R4 new seed done", {31'b0, d[6]}, 32'd1);
    chk("R7 level after auto reseed", {28'b0, d[11:8]}, 32'(DEPTH));
    rd(3'd4, d, e); chk("R7 sequence resumes", d, word_k(RSW));

    // soft reset
    wr(3'd0, 32'h40);
    rd(3'd2, d, e); chk("R11 status after soft reset", d, 32'h0000_5004);
    rd(3'd3, d, e); chk("R11 errors after soft reset", d, 32'h0);
    rd(3'd1, d, e); chk("R11 control kept", d, 32'h30);
    chk("R11 irq after soft reset", {31'b0, irq}, 32'd0);
    rd(3'd4, d, e); chk("R11 fifo emptied", d, 32'h0);
    rd(3'd3, d, e); chk("R11 unseeded again", d, 32'h20);
    wr(3'd0, 32'h20);
    wr(3'd0, 32'h02);
    wait_cmd(32'h2, "R11", d);
    wait_idle("R11");
    rd(3'd4, d, e); chk("R11 sequence restarted", d, word_k(0));

    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule